// File: doc/BRIEF.md
# WAVE Header Stream Parser

This block sits on a byte stream that carries a RIFF/WAVE audio file. It parses the header as the bytes arrive, rebuilds the little-endian length and format fields, and checks that the content is the one format the player can use. That format is a fixed channel count, a fixed sample width and a fixed sample rate, all set by parameters. Once the header has been read in full, the block passes only the audio payload to its output stream. It stops after exactly as many bytes as the data-size field declares.

Two header layouts are accepted. The standard one has a 16-byte format sub-chunk. The extended one has an 18-byte format sub-chunk, so its data-size field and its first sample sit two bytes later. The parser does not use fixed offsets for the data sub-chunk. It reads the format sub-chunk length and places the "data" identifier 20 bytes plus that length into the file. A start pulse begins a new file from any state. A tag mismatch or an unsupported format stops the stream and raises an error flag, which holds until the next start.

Top module: `wav_hdr_parser`

## Requirements
- R1: After reset, and until the first start pulse, `in_ready`, `out_valid`, `hdr_done`, `fmt_err` and `data_end` are 0 and every parsed field output reads 0.
- R2: The four bytes at offsets 0..3 must be ASCII "RIFF", 8..11 "WAVE", 12..15 "fmt ", and the four bytes at offset 20 plus the format length must be "data". A mismatch sets `fmt_err` in the cycle after the last byte of that tag is accepted.
- R3: Multi-byte fields are rebuilt least significant byte first. `riff_size` comes from offsets 4..7 (offset 4 is the low byte), `num_chan` from 22..23, `samp_rate` from 24..27, `samp_bits` from 34..35, and `data_size` from the four bytes after the "data" tag.
- R4: A channel count other than CHANNELS, a sample width other than SAMPLE_BITS, or a rate other than SAMPLE_RATE sets `fmt_err` (defaults 2, 16 and 8000).
- R5: The format length at offsets 16..19 must be 16, or 18 when EXT_OK is 1; any other value sets `fmt_err`. Payload starts at offset 28 plus that length (44 standard, 46 extended).
- R6: While `fmt_err` is 1, `in_ready`, `out_valid` and `hdr_done` stay 0 until the next start.
- R7: While the header is being parsed, `in_ready` is 1 and `out_valid` is 0. `hdr_done` rises in the cycle after the last data-size byte is accepted.
- R8: In the payload phase, `out_valid` follows `in_valid`, `out_data` follows `in_data` and `in_ready` follows `out_ready`, all in the same cycle. Exactly `data_size` bytes are forwarded.
- R9: `data_end` rises in the cycle after the last payload byte is accepted, and `in_ready` stays 0 after that. With a data size of 0, `data_end` rises together with `hdr_done`.
- R10: A start pulse restarts parsing from any state. `in_ready` is 0 during the pulse, and all flags and fields read 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new file |
| in_data | input | 8 | Incoming file byte |
| in_valid | input | 1 | Incoming byte is present |
| in_ready | output | 1 | Parser accepts the incoming byte |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | Forwarded byte is present |
| out_ready | input | 1 | Downstream accepts the forwarded byte |
| riff_size | output | 32 | Parsed RIFF chunk size (file length minus 8) |
| num_chan | output | 16 | Parsed channel count |
| samp_rate | output | 32 | Parsed sample rate |
| samp_bits | output | 16 | Parsed bits per sample |
| data_size | output | 32 | Parsed payload length in bytes |
| hdr_done | output | 1 | Header parsed and accepted |
| fmt_err | output | 1 | Tag mismatch or unsupported format |
| data_end | output | 1 | All payload bytes forwarded |

## Verification
The payload path is combinational, so `out_valid`, `out_data` and `in_ready` are checked one time step after the bench drives each byte, in the same cycle and before the capturing edge. Flags and parsed fields sit one register behind the byte that completes them, so the bench samples them at the falling edge after the rising edge that accepts that byte. Error cases are checked the same way at the end of the header: the flag has risen, and an offered byte is neither taken nor forwarded. Back-pressure and restart are driven at falling edges and checked one half-cycle later.

// File: rtl/wavp_pkg.sv
package wavp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PAY,
      ST_DONE,
      ST_ERR
   } wavp_state_e;

   // Tags as they look after four bytes have entered the little-endian shifter
   localparam logic [31:0] TAG_RIFF = 32'h4646_4952;
   localparam logic [31:0] TAG_WAVE = 32'h4556_4157;
   localparam logic [31:0] TAG_FMT  = 32'h2074_6D66;
   localparam logic [31:0] TAG_DATA = 32'h6174_6164;

   // Offsets of the last byte of each fixed-position field
   localparam logic [15:0] END_RIFF = 16'd3;
   localparam logic [15:0] END_SIZE = 16'd7;
   localparam logic [15:0] END_WAVE = 16'd11;
   localparam logic [15:0] END_FMT  = 16'd15;
   localparam logic [15:0] END_FLEN = 16'd19;
   localparam logic [15:0] END_CHAN = 16'd23;
   localparam logic [15:0] END_RATE = 16'd27;
   localparam logic [15:0] END_BITS = 16'd35;

   // Data tag ends at 23 + fmt length, its size field at 27 + fmt length
   localparam logic [15:0] DTAG_BIAS = 16'd23;
   localparam logic [15:0] DSIZ_BIAS = 16'd27;

   localparam int STD_FMT_LEN = 16;
   localparam int EXT_FMT_LEN = 18;

endpackage

// File: rtl/wavp_le_shift.sv
module wavp_le_shift #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic [7:0]   byte_in,
   output logic [W-1:0] word_nx
);

   logic [W-1:0] word_q;

   initial begin
      if ((W % 8) != 0 || W < 16) $fatal(1, "wavp_le_shift: W must be a multiple of 8, at least 16");
   end

   // newest byte enters at the top, so after N bytes the first one is lowest
   assign word_nx = {byte_in, word_q[W-1:8]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (clr)      word_q <= '0;
      else if (shift_en) word_q <= word_nx;
   end

   // R3
   shift_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clr) |=> (word_q[W-1:W-8] == $past(byte_in)));

endmodule

// File: rtl/wavp_field_check.sv
module wavp_field_check
   import wavp_pkg::*;
#(
   parameter int POS_W       = 6,
   parameter int CHANNELS    = 2,
   parameter int SAMPLE_BITS = 16,
   parameter int SAMPLE_RATE = 8000,
   parameter bit EXT_OK      = 1'b1
) (
   input  logic [POS_W-1:0] pos,
   input  logic [15:0]      fmt_len,
   input  logic [31:0]      word_nx,
   output logic             at_size,
   output logic             at_flen,
   output logic             at_chan,
   output logic             at_rate,
   output logic             at_bits,
   output logic             at_last,
   output logic             bad
);

   localparam logic [15:0] CH_L   = 16'(CHANNELS);
   localparam logic [15:0] BITS_L = 16'(SAMPLE_BITS);
   localparam logic [31:0] RATE_L = 32'(SAMPLE_RATE);

   logic [15:0] p16;
   logic [15:0] dtag_end;
   logic [15:0] dsiz_end;
   logic        len_ok;
   logic        tag_bad;
   logic        fmt_bad;

   assign p16      = 16'(pos);
   assign dtag_end = DTAG_BIAS + fmt_len;
   assign dsiz_end = DSIZ_BIAS + fmt_len;

   generate
      if (EXT_OK) begin : g_ext
         assign len_ok = (word_nx == 32'(STD_FMT_LEN)) || (word_nx == 32'(EXT_FMT_LEN));
      end else begin : g_std
         assign len_ok = (word_nx == 32'(STD_FMT_LEN));
      end
   endgenerate

   assign at_size = (p16 == END_SIZE);
   assign at_flen = (p16 == END_FLEN);
   assign at_chan = (p16 == END_CHAN);
   assign at_rate = (p16 == END_RATE);
   assign at_bits = (p16 == END_BITS);
   assign at_last = (p16 > END_BITS) && (p16 == dsiz_end);

   always_comb begin
      tag_bad = 1'b0;
      if (p16 == END_RIFF && word_nx != TAG_RIFF) tag_bad = 1'b1;
      if (p16 == END_WAVE && word_nx != TAG_WAVE) tag_bad = 1'b1;
      if (p16 == END_FMT  && word_nx != TAG_FMT)  tag_bad = 1'b1;
      if (p16 > END_BITS && p16 == dtag_end && word_nx != TAG_DATA) tag_bad = 1'b1;
   end

   always_comb begin
      fmt_bad = 1'b0;
      if (at_flen && !len_ok)                   fmt_bad = 1'b1;
      if (at_chan && word_nx[31:16] != CH_L)    fmt_bad = 1'b1;
      if (at_rate && word_nx != RATE_L)         fmt_bad = 1'b1;
      if (at_bits && word_nx[31:16] != BITS_L)  fmt_bad = 1'b1;
   end

   assign bad = tag_bad || fmt_bad;

endmodule

// File: rtl/wavp_payload_cnt.sv
module wavp_payload_cnt #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          take,
   output logic          last,
   output logic          zero
);

   logic [CW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rem_q <= '0;
      else if (load)                    rem_q <= load_val;
      else if (take && rem_q != '0)     rem_q <= rem_q - 1'b1;
   end

   assign last = (rem_q == CW'(1));
   assign zero = (rem_q == '0);

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !load && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));

   // R8
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !load) |=> $stable(rem_q));

endmodule

// File: rtl/wav_hdr_parser.sv
module wav_hdr_parser
   import wavp_pkg::*;
#(
   parameter int CHANNELS    = 2,
   parameter int SAMPLE_BITS = 16,
   parameter int SAMPLE_RATE = 8000,
   parameter bit EXT_OK      = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [7:0]  in_data,
   input  logic        in_valid,
   output logic        in_ready,
   output logic [7:0]  out_data,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [31:0] riff_size,
   output logic [15:0] num_chan,
   output logic [31:0] samp_rate,
   output logic [15:0] samp_bits,
   output logic [31:0] data_size,
   output logic        hdr_done,
   output logic        fmt_err,
   output logic        data_end
);

   localparam int MAX_FLEN = EXT_OK ? EXT_FMT_LEN : STD_FMT_LEN;
   localparam int HDR_MAX  = 28 + MAX_FLEN;
   localparam int POS_W    = $clog2(HDR_MAX + 1);

   initial begin
      if (CHANNELS < 1 || CHANNELS > 65535) $fatal(1, "wav_hdr_parser: CHANNELS out of range");
      if (SAMPLE_BITS < 8 || (SAMPLE_BITS % 8) != 0) $fatal(1, "wav_hdr_parser: SAMPLE_BITS must be whole bytes");
      if (SAMPLE_RATE < 1) $fatal(1, "wav_hdr_parser: SAMPLE_RATE must be positive");
   end

   wavp_state_e      state_q;
   logic [POS_W-1:0] pos_q;
   logic [15:0]      flen_q;
   logic [31:0]      word_nx;
   logic             fire;
   logic             hdr_fire;
   logic             pay_fire;
   logic             at_size, at_flen, at_chan, at_rate, at_bits, at_last, bad;
   logic             cnt_last, cnt_zero;

   // ready and payload forwarding
   always_comb begin
      in_ready = 1'b0;
      if (!start) begin
         unique case (state_q)
            ST_HDR:  in_ready = 1'b1;
            ST_PAY:  in_ready = out_ready;
            default: in_ready = 1'b0;
         endcase
      end
   end

   assign out_valid = (state_q == ST_PAY) && in_valid && !start;
   assign out_data  = in_data;

   assign fire     = in_valid && in_ready;
   assign hdr_fire = fire && (state_q == ST_HDR);
   assign pay_fire = fire && (state_q == ST_PAY);

   wavp_le_shift #(.W(32)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .shift_en (hdr_fire),
      .byte_in  (in_data),
      .word_nx  (word_nx)
   );

   wavp_field_check #(
      .POS_W       (POS_W),
      .CHANNELS    (CHANNELS),
      .SAMPLE_BITS (SAMPLE_BITS),
      .SAMPLE_RATE (SAMPLE_RATE),
      .EXT_OK      (EXT_OK)
   ) u_check (
      .pos     (pos_q),
      .fmt_len (flen_q),
      .word_nx (word_nx),
      .at_size (at_size),
      .at_flen (at_flen),
      .at_chan (at_chan),
      .at_rate (at_rate),
      .at_bits (at_bits),
      .at_last (at_last),
      .bad     (bad)
   );

   wavp_payload_cnt #(.CW(32)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hdr_fire && at_last && !bad),
      .load_val (word_nx),
      .take     (pay_fire),
      .last     (cnt_last),
      .zero     (cnt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pos_q     <= '0;
         flen_q    <= '0;
         riff_size <= '0;
         num_chan  <= '0;
         samp_rate <= '0;
         samp_bits <= '0;
         data_size <= '0;
         hdr_done  <= 1'b0;
         fmt_err   <= 1'b0;
         data_end  <= 1'b0;
      end else if (start) begin
         state_q   <= ST_HDR;
         pos_q     <= '0;
         flen_q    <= '0;
         riff_size <= '0;
         num_chan  <= '0;
         samp_rate <= '0;
         samp_bits <= '0;
         data_size <= '0;
         hdr_done  <= 1'b0;
         fmt_err   <= 1'b0;
         data_end  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_HDR: begin
               if (hdr_fire) begin
                  pos_q <= pos_q + 1'b1;
                  if (at_size) riff_size <= word_nx;
                  if (at_flen) flen_q    <= word_nx[15:0];
                  if (at_chan) num_chan  <= word_nx[31:16];
                  if (at_rate) samp_rate <= word_nx;
                  if (at_bits) samp_bits <= word_nx[31:16];
                  if (bad) begin
                     state_q <= ST_ERR;
                     fmt_err <= 1'b1;
                  end else if (at_last) begin
                     data_size <= word_nx;
                     hdr_done  <= 1'b1;
                     if (word_nx == '0) begin
                        state_q  <= ST_DONE;
                        data_end <= 1'b1;
                     end else begin
                        state_q  <= ST_PAY;
                     end
                  end
               end
            end
            ST_PAY: begin
               if (pay_fire && cnt_last) begin
                  state_q  <= ST_DONE;
                  data_end <= 1'b1;
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   // R6
   err_blocks_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> (!out_valid && !in_ready));

   // R6
   done_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_done && fmt_err));

   // R7
   hdr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_done |-> !out_valid);

   // R9
   end_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_end |-> cnt_zero);

   // R9
   end_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_end |-> !in_ready);

   // R10
   restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!hdr_done && !fmt_err && !data_end));

endmodule

// File: tb/sim_wav_hdr_parser.sv
module sim_wav_hdr_parser;

   typedef struct packed {
      logic [7:0]  flen;
      logic [15:0] ch;
      logic [31:0] rate;
      logic [15:0] bits;
      logic [7:0]  pay;
      logic [7:0]  bad_ix;
      logic        err;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{8'd16, 16'd2, 32'd8000,  16'd16, 8'd6, 8'd255, 1'b0},
      '{8'd18, 16'd2, 32'd8000,  16'd16, 8'd5, 8'd255, 1'b0},
      '{8'd16, 16'd1, 32'd8000,  16'd16, 8'd4, 8'd255, 1'b1},
      '{8'd16, 16'd2, 32'd44100, 16'd16, 8'd4, 8'd255, 1'b1},
      '{8'd16, 16'd2, 32'd8000,  16'd8,  8'd4, 8'd255, 1'b1},
      '{8'd16, 16'd2, 32'd8000,  16'd16, 8'd4, 8'd1,   1'b1},
      '{8'd18, 16'd2, 32'd8000,  16'd16, 8'd4, 8'd10,  1'b1},
      '{8'd18, 16'd2, 32'd8000,  16'd16, 8'd4, 8'd13,  1'b1},
      '{8'd18, 16'd2, 32'd8000,  16'd16, 8'd4, 8'd39,  1'b1},
      '{8'd20, 16'd2, 32'd8000,  16'd16, 8'd4, 8'd255, 1'b1},
      '{8'd16, 16'd2, 32'd8000,  16'd16, 8'd0, 8'd255, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] riff_size, samp_rate, data_size;
   logic [15:0] num_chan, samp_bits;
   logic        hdr_done, fmt_err, data_end;

   int nchk = 0;
   int nfail = 0;
   logic [7:0] hb [0:63];
   int hlen;

   always #10 clk = ~clk;

   wav_hdr_parser u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .riff_size(riff_size), .num_chan(num_chan), .samp_rate(samp_rate),
      .samp_bits(samp_bits), .data_size(data_size),
      .hdr_done(hdr_done), .fmt_err(fmt_err), .data_end(data_end)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push8(input logic [7:0] b);
      hb[hlen] = b;
      hlen++;
   endtask

   task automatic push16(input logic [15:0] v);
      push8(v[7:0]); push8(v[15:8]);
   endtask

   task automatic push32(input logic [31:0] v);
      push16(v[15:0]); push16(v[31:16]);
   endtask

   task automatic pushtag(input logic [31:0] t);
      push8(t[31:24]); push8(t[23:16]); push8(t[15:8]); push8(t[7:0]);
   endtask

   task automatic build(input vec_t v);
      int ext;
      ext = int'(v.flen) - 16;
      hlen = 0;
      pushtag("RIFF");
      push32(32'(36 + ext + int'(v.pay)));
      pushtag("WAVE");
      pushtag("fmt ");
      push32(32'(v.flen));
      push16(16'd1);
      push16(v.ch);
      push32(v.rate);
      push32(32'(int'(v.rate) * int'(v.ch) * int'(v.bits) / 8));
      push16(16'(int'(v.ch) * int'(v.bits) / 8));
      push16(v.bits);
      for (int i = 0; i < ext; i++) push8(8'h00);
      pushtag("data");
      push32(32'(v.pay));
      if (v.bad_ix != 8'd255) hb[v.bad_ix] = hb[v.bad_ix] ^ 8'h20;
   endtask

   function automatic logic [7:0] pbyte(input int v, input int k);
      return 8'((v * 16 + k) ^ 8'hA5);
   endfunction

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      in_valid = 1'b0;
      #1;
      chk("R10 ready low during start", 32'(in_ready), 32'd0);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic feed_header(input bit watch);
      for (int i = 0; i < hlen; i++) begin
         @(negedge clk);
         in_data = hb[i];
         in_valid = 1'b1;
         #1;
         if (watch && (i == 5 || i == hlen - 1)) begin
            chk("R7 header ready", 32'(in_ready), 32'd1);
            chk("R7 header silent", 32'(out_valid), 32'd0);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1;
      in_data = 8'h52;
      @(negedge clk);
      #1;
      chk("R1 in_ready", 32'(in_ready), 32'd0);
      chk("R1 out_valid", 32'(out_valid), 32'd0);
      chk("R1 flags", {29'd0, hdr_done, fmt_err, data_end}, 32'd0);
      chk("R1 riff_size", riff_size, 32'd0);
      chk("R1 data_size", data_size, 32'd0);
      chk("R1 num_chan", 32'(num_chan), 32'd0);
      in_valid = 1'b0;

      // table walk
      for (int v = 0; v < NV; v++) begin
         build(VT[v]);
         pulse_start();
         feed_header(!VT[v].err);
         if (VT[v].err) begin
            chk("R2 R4 R5 error flag", 32'(fmt_err), 32'd1);
            chk("R6 no header done", 32'(hdr_done), 32'd0);
            in_valid = 1'b1;
            in_data = 8'h33;
            #1;
            chk("R6 input stalled", 32'(in_ready), 32'd0);
            chk("R6 payload blocked", 32'(out_valid), 32'd0);
            in_valid = 1'b0;
         end else begin
            chk("R7 header done", 32'(hdr_done), 32'd1);
            chk("R2 no error", 32'(fmt_err), 32'd0);
            chk("R3 riff_size", riff_size, 32'(36 + int'(VT[v].flen) - 16 + int'(VT[v].pay)));
            chk("R3 num_chan", 32'(num_chan), 32'(VT[v].ch));
            chk("R3 samp_rate", samp_rate, VT[v].rate);
            chk("R3 samp_bits", 32'(samp_bits), 32'(VT[v].bits));
            chk("R3 R5 data_size", data_size, 32'(VT[v].pay));
            if (VT[v].pay == 8'd0)
               chk("R9 zero size ends at once", 32'(data_end), 32'd1);
            for (int k = 0; k < int'(VT[v].pay); k++) begin
               @(negedge clk);
               in_data = pbyte(v, k);
               in_valid = 1'b1;
               #1;
               chk("R8 out_valid", 32'(out_valid), 32'd1);
               chk("R8 out_data", 32'(out_data), 32'(pbyte(v, k)));
               chk("R9 not ended early", 32'(data_end), 32'd0);
            end
            @(negedge clk);
            in_data = 8'h77;
            in_valid = 1'b1;
            #1;
            chk("R9 data_end", 32'(data_end), 32'd1);
            chk("R9 stalled after end", 32'(in_ready), 32'd0);
            chk("R8 no extra byte", 32'(out_valid), 32'd0);
            in_valid = 1'b0;
         end
      end

      // back-pressure in the payload phase
      build('{8'd16, 16'd2, 32'd8000, 16'd16, 8'd3, 8'd255, 1'b0});
      pulse_start();
      feed_header(1'b0);
      @(negedge clk);
      in_data = 8'h11;
      in_valid = 1'b1;
      out_ready = 1'b0;
      #1;
      chk("R8 ready follows out_ready", 32'(in_ready), 32'd0);
      chk("R8 valid while held", 32'(out_valid), 32'd1);
      @(negedge clk);
      #1;
      chk("R8 data held", 32'(out_data), 32'h11);
      out_ready = 1'b1;
      #1;
      chk("R8 ready released", 32'(in_ready), 32'd1);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         in_data = 8'(8'h22 + k);
         #1;
         chk("R9 count after stall", 32'(data_end), 32'd0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk("R9 end after three bytes", 32'(data_end), 32'd1);

      // restart in the middle of a payload
      build('{8'd18, 16'd2, 32'd8000, 16'd16, 8'd9, 8'd255, 1'b0});
      pulse_start();
      feed_header(1'b0);
      @(negedge clk);
      in_data = 8'h5A;
      in_valid = 1'b1;
      @(negedge clk);
      start = 1'b1;
      #1;
      chk("R10 start blocks output", 32'(out_valid), 32'd0);
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
      #1;
      chk("R10 flags cleared", {29'd0, hdr_done, fmt_err, data_end}, 32'd0);
      chk("R10 fields cleared", data_size, 32'd0);
      chk("R10 header phase", 32'(in_ready), 32'd1);
      build('{8'd16, 16'd2, 32'd8000, 16'd16, 8'd2, 8'd255, 1'b0});
      feed_header(1'b1);
      chk("R10 reparsed", data_size, 32'd2);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule